// File: doc/BRIEF.md
# Output Latency Pipeline with Input Blanking

This block moves converted sample words from the converter stage onto the parallel output bus. It has a fixed latency, and one rising clock edge advances the whole path. In normal operation a sample reaches the output nine registers after it is captured. An active-low blanking input travels in a parallel flag chain that is eleven registers deep. Whenever the delayed flag arrives at the output, the output word is forced to zero. The zeroing therefore lines up with the pipeline and does not start at the edge where blanking is first seen.

A standby bit from the register block forces the output to zero on the next edge. It takes priority over both the blanking path and the data path. The pipeline keeps advancing during standby, so data resumes on the first edge after standby is released. The asynchronous active-low reset clears every stage and the output. It is released through a two-flop synchronizer, so the pipeline captures its first sample on the third rising edge after reset is removed.

Top module: `outlat_pipe`

## Requirements
- R1: With blanking inactive and standby low, a sample captured on rising edge k appears on `data_o` after edge k+8, which is the ninth register edge counting the capture edge as the first.
- R2: `blank_n_i` is active low. A low level sampled on edge k forces `data_o` to all zeros after edge k+10, the eleventh edge. The outputs after edges k+8 and k+9 still carry the normal-path samples from edges k and k+1.
- R3: If `blank_n_i` is sampled low on m consecutive edges, exactly m consecutive output words are zero, provided every sample is nonzero and standby stays low.
- R4: If the last low sample of `blank_n_i` is on edge k-1, the output after edge k+9 is zero. The output after edge k+10 is the sample captured on edge k+2, so no word taken before the release is emitted after the zeros.
- R5: `standby_i` sampled high on edge n forces `data_o` to zero after edge n, whatever the blanking and data inputs are. When standby is sampled low again on edge n+1, the output after that edge is the sample from edge n-7.
- R6: A low level on `rst_n` clears `data_o` at once and clears every pipeline stage. After release, the first eight output words are zero, and no sample taken before the reset ever appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_i | input | WIDTH | Converted sample word entering the pipeline |
| blank_n_i | input | 1 | Input blanking, active low |
| standby_i | input | 1 | Standby bit from the register block; forces output to zero |
| data_o | output | WIDTH | Delayed output data word |

## Verification
If a data stage is dropped or duplicated, every sample appears one edge early or late, and the first nonzero word after reset shows it within nine edges. If the flag chain has the wrong depth or polarity, zeros appear too early, too late or inverted, at the tenth or eleventh edge after blanking is applied. A release that leaks pre-blanking words shows up as a nonzero word where the window expects a fresh sample. A standby path that is not registered, or that is overridden by the data path, shows a nonzero word on the first edge of standby.

// File: rtl/outlat_pkg.sv
`timescale 1ns/1ps
package outlat_pkg;

  // Source selected for the output register on each edge.
  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_BLANK = 2'd1,
    SEL_STBY  = 2'd2
  } out_sel_e;

endpackage

// File: rtl/outlat_rst_sync.sv
`timescale 1ns/1ps
module outlat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/outlat_tap_chain.sv
`timescale 1ns/1ps
module outlat_tap_chain #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n_sync,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] tap_o
);

  logic [DEPTH-1:0][WIDTH-1:0] stage_q;
  logic [DEPTH-1:0][WIDTH-1:0] stage_d;

  // Next-state: each stage takes its upstream neighbour, the head takes the input.
  generate
    if (DEPTH == 1) begin : g_single
      always_comb begin
        stage_d[0] = d_i;
      end
    end else begin : g_multi
      always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < DEPTH; i++) begin
          stage_d[i] = stage_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign tap_o = stage_q[DEPTH-1];

endmodule

// File: rtl/outlat_out_stage.sv
`timescale 1ns/1ps
module outlat_out_stage
  import outlat_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n_sync,
  input  logic [WIDTH-1:0] data_tap_i,
  input  logic             blank_tap_i,
  input  logic             standby_i,
  output logic [WIDTH-1:0] data_o
);

  out_sel_e         sel;
  logic [WIDTH-1:0] data_d;

  // Standby wins over the delayed blanking flag, which wins over data.
  always_comb begin
    if (standby_i) begin
      sel = SEL_STBY;
    end else if (blank_tap_i) begin
      sel = SEL_BLANK;
    end else begin
      sel = SEL_DATA;
    end
    case (sel)
      SEL_DATA: data_d = data_tap_i;
      default:  data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      data_o <= '0;
    end else begin
      data_o <= data_d;
    end
  end

  // R5: standby seen on an edge leaves a zero word behind that edge.
  assert_standby_zero_R5: assert property (
    @(posedge clk) disable iff (!rst_n_sync)
    standby_i |=> (data_o == '0)
  );

endmodule

// File: rtl/outlat_pipe.sv
`timescale 1ns/1ps
module outlat_pipe #(
  parameter int WIDTH     = 12,
  parameter int NORM_LAT  = 9,
  parameter int BLANK_LAT = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sample_i,
  input  logic             blank_n_i,
  input  logic             standby_i,
  output logic [WIDTH-1:0] data_o
);

  // The output register supplies the last stage of each latency.
  localparam int DATA_DEPTH = NORM_LAT - 1;
  localparam int FLAG_DEPTH = BLANK_LAT - 1;
  localparam int WARM_MAX   = BLANK_LAT + 1;
  localparam int WARM_W     = $clog2(WARM_MAX + 1);

  logic             rst_n_sync;
  logic [WIDTH-1:0] data_tap;
  logic [0:0]       flag_in;
  logic [0:0]       flag_tap;

  assign flag_in = ~blank_n_i;

  outlat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  outlat_tap_chain #(
    .WIDTH (WIDTH),
    .DEPTH (DATA_DEPTH)
  ) u_data (
    .clk        (clk),
    .rst_n_sync (rst_n_sync),
    .d_i        (sample_i),
    .tap_o      (data_tap)
  );

  outlat_tap_chain #(
    .WIDTH (1),
    .DEPTH (FLAG_DEPTH)
  ) u_flag (
    .clk        (clk),
    .rst_n_sync (rst_n_sync),
    .d_i        (flag_in),
    .tap_o      (flag_tap)
  );

  outlat_out_stage #(
    .WIDTH (WIDTH)
  ) u_out (
    .clk         (clk),
    .rst_n_sync  (rst_n_sync),
    .data_tap_i  (data_tap),
    .blank_tap_i (flag_tap[0]),
    .standby_i   (standby_i),
    .data_o      (data_o)
  );

  // Edges since reset release, saturating; gates the history-based checks.
  logic [WARM_W-1:0] warm_cnt;
  logic [WARM_W-1:0] warm_cnt_d;
  logic              warm;

  always_comb begin
    warm       = (warm_cnt == WARM_W'(WARM_MAX));
    warm_cnt_d = warm ? warm_cnt : warm_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      warm_cnt <= '0;
    end else begin
      warm_cnt <= warm_cnt_d;
    end
  end

  // R1 (and R4 on release): unblanked, non-standby output equals the sample NORM_LAT-1 edges back.
  assert_norm_latency_R1: assert property (
    @(posedge clk) disable iff (!rst_n_sync)
    (warm && !$past(standby_i) && $past(blank_n_i, BLANK_LAT))
      |-> (data_o == $past(sample_i, NORM_LAT))
  );

  // R2 (and R3 by repetition): blanking sampled BLANK_LAT-1 edges back zeroes the word.
  assert_blank_zero_R2: assert property (
    @(posedge clk) disable iff (!rst_n_sync)
    (warm && !$past(blank_n_i, BLANK_LAT)) |-> (data_o == '0)
  );

  // R6: output is clear whenever reset is held.
  assert_reset_clear_R6: assert property (
    @(posedge clk) !rst_n |-> (data_o == '0)
  );

endmodule

// File: tb/sim_outlat_pipe.sv
`timescale 1ns/1ps
module sim_outlat_pipe;

  localparam int W   = 12;
  localparam int HN  = 512;
  localparam int NP  = 48;

  // Table rows: {blank_n, standby}. 2'b10 normal, 2'b00 blank, 2'b11 standby, 2'b01 both.
  localparam logic [1:0] PAT [NP] = '{
    2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10,
    2'b00, 2'b00, 2'b00,
    2'b10, 2'b10, 2'b10, 2'b10, 2'b10,
    2'b00,
    2'b10, 2'b10, 2'b10, 2'b10,
    2'b11, 2'b11,
    2'b10, 2'b10, 2'b10,
    2'b01, 2'b01,
    2'b00, 2'b00,
    2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10,
    2'b11,
    2'b00,
    2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10,
    2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] smp;
  logic         bn;
  logic         sb;
  logic [W-1:0] dq;

  always #10 clk = ~clk;

  outlat_pipe #(.WIDTH(W), .NORM_LAT(9), .BLANK_LAT(11)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_i  (smp),
    .blank_n_i (bn),
    .standby_i (sb),
    .data_o    (dq)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int idx    = 16;
  logic [W-1:0] h_d [HN];
  logic         h_b [HN];
  logic         h_s [HN];
  logic [W-1:0] h_o [HN];

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input int n);
    if (h_s[n])       return '0;
    if (!h_b[n-10])   return '0;
    return h_d[n-8];
  endfunction

  function automatic string auto_tag(input int n);
    if (h_s[n])     return "R5";
    if (!h_b[n-10]) return "R2";
    if (!h_b[n-11]) return "R4";
    return "R1";
  endfunction

  task automatic prefill();
    for (int k = idx - 16; k < idx; k++) begin
      h_d[k] = '0; h_b[k] = 1'b1; h_s[k] = 1'b0; h_o[k] = '0;
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, check at the next falling edge.
  task automatic step(input logic b, input logic s, input string tag);
    logic [W-1:0] d;
    d = W'(32'h800 | idx);
    smp = d; bn = b; sb = s;
    h_d[idx] = d; h_b[idx] = b; h_s[idx] = s;
    @(posedge clk);
    @(negedge clk);
    h_o[idx] = dq;
    chk((tag == "") ? auto_tag(idx) : tag, dq, model(idx));
    idx++;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    int base;
    int zeros;
    rst_n = 1'b1; smp = 12'hABC; bn = 1'b1; sb = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6", dq, '0);                       // reset state
    rst_n = 1'b1;
    smp = '0;
    repeat (3) @(negedge clk);
    prefill();
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, "R6");

    // Table walk: every output word checked against the model.
    for (int i = 0; i < NP; i++) step(PAT[i][1], PAT[i][0], "");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "");

    // R2 / R4: single blanked sample, exact edge of the zero word.
    base = idx;
    step(1'b0, 1'b0, "");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "");
    chk("R2", h_o[base+8], h_d[base]);
    chk("R2", h_o[base+9], h_d[base+1]);
    chk("R2", h_o[base+10], '0);
    chk("R4", h_o[base+11], h_d[base+3]);

    // R3: five consecutive blanked samples give five zero words.
    base = idx;
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "");
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, "");
    zeros = 0;
    for (int k = base; k < base + 21; k++) if (h_o[k] == '0) zeros++;
    chk("R3", W'(zeros), W'(5));

    // R5: standby wins immediately, also over blanking; release resumes at once.
    base = idx;
    step(1'b1, 1'b1, "");
    step(1'b0, 1'b1, "");
    step(1'b1, 1'b0, "");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "");
    chk("R5", h_o[base], '0);
    chk("R5", h_o[base+1], '0);
    chk("R5", h_o[base+2], h_d[base-6]);

    // R6: reset in mid-stream clears output at once and drops stale samples.
    rst_n = 1'b0;
    #1 chk("R6", dq, '0);
    @(negedge clk);
    rst_n = 1'b1;
    smp = '0;
    repeat (3) @(negedge clk);
    prefill();
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, "R6");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "");

    report();
    $finish;
  end

endmodule